// File: doc/BRIEF.md
# Presence-Tracking Hold Stage with Bypass

This block is the control wrapper around a one-word hold store. The store keeps an operand until its partner is ready, or parks one item in front of a shared device. The block does not hold the word itself. It produces the read strobe that releases the word and keeps three facts about it:

- whether a new word has arrived since the last release,
- whether the downstream device is occupied,
- whether a write landed on a word that was never read.

The block works in one of two modes, chosen by `q_mode`:

- **Queue mode** (`q_mode` = 1). The device-busy flag steers the release.
  - If the device is free, the write strobe itself starts a release, after the store's minimum write-to-read separation.
  - If the device is occupied, the word waits. The device's done strobe, which marks the departing item, becomes the release.
- **Holder mode** (`q_mode` = 0). Releases come only from explicit read requests.
  - A request that finds no new word is refused.
  - It is retried once every store loop period until a word is present.

The controller is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing pending. |
| `ST_SEP` | A bypass release is counting the separation. |
| `ST_WAIT` | A word is parked behind a busy device. |
| `ST_RETRY` | A refused request is waiting for the next loop period. |

Its transitions:

| Transition | Condition |
|---|---|
| `ST_IDLE` → `ST_SEP` | Queue mode, a word is present, and the device is free or finishing. |
| `ST_IDLE` → `ST_WAIT` | Queue mode, a word is present, and the device is busy. |
| `ST_IDLE` → `ST_RETRY` | Holder mode, a request arrives, and no word is present. |
| `ST_SEP` → `ST_IDLE` | The separation expires; the word is released. |
| `ST_WAIT` → `ST_IDLE` | A done strobe arrives; the word is released. |
| `ST_RETRY` → `ST_IDLE` | A retry finds a word; the word is released. |
| `ST_RETRY` → `ST_RETRY` | A retry finds no word and reloads the loop timer. |

Top module: `hs_hold_stage`

## Requirements
- R1: `data_new` rises in the cycle after a sampled `wr_stb` and falls in the cycle in which `rd_stb` is high. When a write and a release fall on the same edge, the write wins and `data_new` stays 1.
- R2: In holder mode (`q_mode`=0), a sampled `rd_req` with `data_new`=1 makes `rd_stb` high in the cycle right after that edge.
- R3: In holder mode, a sampled `rd_req` with `data_new`=0 behaves as follows:
  - `rd_block` pulses in the next cycle and no `rd_stb` is produced.
  - The request is re-tested LOOP_LEN edges later. If `data_new`=1 then, `rd_stb` goes high in the following cycle. Otherwise `rd_block` pulses again and the re-test repeats every LOOP_LEN edges.
- R4: In queue mode with the device free, a write sampled at edge k makes `rd_stb` high for exactly one cycle after edge k+MIN_SEP.
- R5: In queue mode with the device busy, a written word is held without a strobe. `rd_stb` goes high in the cycle after the edge that samples `dev_done`.
- R6: `dev_busy` rises with every `rd_stb` and falls in the cycle after a sampled `dev_done`. When a release and a done strobe fall on the same edge, `dev_busy` stays 1.
- R7: A write sampled while `data_new`=1 makes `overflow` high for exactly the next cycle. The new word replaces the old one and the pending release timing is unchanged.
- R8: Each mode ignores the other mode's trigger:
  - Queue mode ignores `rd_req`.
  - Holder mode issues no release on a write alone.
- R9: During and right after reset, all outputs are 0.
- R10: Every `rd_stb` is preceded by `data_new`=1 in the cycle before it. `rd_block` and `rd_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_mode | input | 1 | 1 = queue mode (busy-steered release), 0 = holder mode (requested release) |
| wr_stb | input | 1 | Write strobe of the held word |
| rd_req | input | 1 | Read request (holder mode) |
| dev_done | input | 1 | Strobe of the item leaving the downstream device |
| rd_stb | output | 1 | Release strobe to the store and the device |
| rd_block | output | 1 | Pulse: a read request found no new word |
| data_new | output | 1 | A word has been written since the last release |
| dev_busy | output | 1 | The downstream device is occupied |
| overflow | output | 1 | Pulse: an unread word was overwritten |

## Verification
The properties checked on every cycle are these:

- the write/release effect on the new-data flag,
- the release/done effect on the busy flag,
- that no release is issued without a new word,
- that refusals happen only on an empty stage,
- the origin of overflow pulses.

The exact release timing can be shown only by the bench's scenarios. That covers the separation delay of a bypass release, the one-cycle answer to a parked word's done strobe, and the LOOP_LEN retry period, including a second failed retry. The scenarios also show that each mode ignores the other mode's trigger.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEP,
        ST_WAIT,
        ST_RETRY
    } hs_state_e;

endpackage

// File: rtl/hs_presence.sv
// New-data flag and overflow pulse for the held word.
module hs_presence (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic fire_i,
    output logic fresh_o,
    output logic ovf_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            // a write on the release edge keeps the flag set
            if (wr_i)
                fresh_o <= 1'b1;
            else if (fire_i)
                fresh_o <= 1'b0;
            ovf_o <= wr_i & fresh_o;
        end
    end

endmodule

// File: rtl/hs_busy.sv
// Occupancy flag of the downstream device.
module hs_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic done_i,
    output logic busy_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_o <= 1'b0;
        else if (fire_i)
            busy_o <= 1'b1;
        else if (done_i)
            busy_o <= 1'b0;
    end

endmodule

// File: rtl/hs_timer.sv
// Loadable down counter shared by the separation and retry waits.
module hs_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_i)
            cnt <= load_val_i;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign zero_o = (cnt == '0);

endmodule

// File: rtl/hs_hold_stage.sv
module hs_hold_stage #(
    parameter int MIN_SEP  = 3,
    parameter int LOOP_LEN = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q_mode,
    input  logic wr_stb,
    input  logic rd_req,
    input  logic dev_done,
    output logic rd_stb,
    output logic rd_block,
    output logic data_new,
    output logic dev_busy,
    output logic overflow
);
    import hs_pkg::*;

    localparam int TMAX = (LOOP_LEN > MIN_SEP) ? LOOP_LEN : MIN_SEP;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] SEP_LD = CW'(MIN_SEP - 1);
    localparam logic [CW-1:0] RET_LD = CW'(LOOP_LEN - 1);

    hs_state_e     st, st_nxt;
    logic          fire, blk;
    logic          tmr_ld, tmr_zero;
    logic [CW-1:0] tmr_val;

    hs_presence u_presence (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_stb),
        .fire_i  (fire),
        .fresh_o (data_new),
        .ovf_o   (overflow)
    );

    hs_busy u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .done_i (dev_done),
        .busy_o (dev_busy)
    );

    hs_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_ld),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // next state and release decision
    always_comb begin
        st_nxt  = st;
        fire    = 1'b0;
        blk     = 1'b0;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (st)
            ST_IDLE: begin
                if (q_mode) begin
                    if (wr_stb || data_new) begin
                        if (dev_busy && !dev_done) begin
                            st_nxt = ST_WAIT;
                        end else begin
                            st_nxt  = ST_SEP;
                            tmr_ld  = 1'b1;
                            tmr_val = SEP_LD;
                        end
                    end
                end else if (rd_req) begin
                    if (data_new) begin
                        fire = 1'b1;
                    end else begin
                        blk     = 1'b1;
                        st_nxt  = ST_RETRY;
                        tmr_ld  = 1'b1;
                        tmr_val = RET_LD;
                    end
                end
            end
            ST_SEP: begin
                if (tmr_zero) begin
                    fire   = 1'b1;
                    st_nxt = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (dev_done) begin
                    fire   = 1'b1;
                    st_nxt = ST_IDLE;
                end
            end
            ST_RETRY: begin
                if (tmr_zero) begin
                    if (data_new) begin
                        fire   = 1'b1;
                        st_nxt = ST_IDLE;
                    end else begin
                        blk     = 1'b1;
                        tmr_ld  = 1'b1;
                        tmr_val = RET_LD;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb   <= 1'b0;
            rd_block <= 1'b0;
        end else begin
            rd_stb   <= fire;
            rd_block <= blk;
        end
    end

endmodule

// File: rtl/hs_hold_stage_chk.sv
module hs_hold_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic dev_done,
    input logic rd_stb,
    input logic rd_block,
    input logic data_new,
    input logic dev_busy,
    input logic overflow
);

    AST_WRITE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> data_new);                                             // R1

    AST_RELEASE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !$past(wr_stb)) |-> !data_new);                         // R1

    AST_BLOCK_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_block |-> !$past(data_new));                                    // R3

    AST_BUSY_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> dev_busy);                                              // R6

    AST_BUSY_FREED_BY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_busy) |-> $past(dev_done));                              // R6

    AST_OVERFLOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(wr_stb) && $past(data_new)));                  // R7

    AST_RELEASE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(data_new));                                       // R10

    AST_NO_BLOCK_AND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && rd_block));                                            // R10

endmodule

bind hs_hold_stage hs_hold_stage_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .dev_done (dev_done),
    .rd_stb   (rd_stb),
    .rd_block (rd_block),
    .data_new (data_new),
    .dev_busy (dev_busy),
    .overflow (overflow)
);

// File: tb/test_hs_hold_stage.sv
`timescale 1ns/1ps
module test_hs_hold_stage;

    localparam int MS = 3;
    localparam int LL = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic q_mode = 1'b0;
    logic wr_stb = 1'b0;
    logic rd_req = 1'b0;
    logic dev_done = 1'b0;
    logic rd_stb, rd_block, data_new, dev_busy, overflow;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int    stb_cyc[$];
    string stb_req[$];
    int    blk_cyc[$];
    string blk_req[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_hold_stage #(.MIN_SEP(MS), .LOOP_LEN(LL)) i_hs_hold_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_mode   (q_mode),
        .wr_stb   (wr_stb),
        .rd_req   (rd_req),
        .dev_done (dev_done),
        .rd_stb   (rd_stb),
        .rd_block (rd_block),
        .data_new (data_new),
        .dev_busy (dev_busy),
        .overflow (overflow)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_stb(int at, string req);
        stb_cyc.push_back(at);
        stb_req.push_back(req);
    endtask

    task automatic expect_blk(int at, string req);
        blk_cyc.push_back(at);
        blk_req.push_back(req);
    endtask

    task automatic do_write();
        wr_stb = 1'b1;
        tick(1);
        wr_stb = 1'b0;
    endtask

    task automatic do_req();
        rd_req = 1'b1;
        tick(1);
        rd_req = 1'b0;
    endtask

    task automatic do_done();
        dev_done = 1'b1;
        tick(1);
        dev_done = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_stb) begin
                if (stb_cyc.size() == 0)
                    check_eq("R8", "unexpected rd_stb at cycle", cyc, -1);
                else
                    check_eq(stb_req.pop_front(), "rd_stb cycle", cyc, stb_cyc.pop_front());
            end
            if (rd_block) begin
                if (blk_cyc.size() == 0)
                    check_eq("R8", "unexpected rd_block at cycle", cyc, -1);
                else
                    check_eq(blk_req.pop_front(), "rd_block cycle", cyc, blk_cyc.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            report();
        end
    end

    initial begin
        int e;
        int r;
        int d;
        tick(3);
        check_eq("R9", "rd_stb in reset", int'(rd_stb), 0);
        rst_n = 1'b1;
        tick(1);
        check_eq("R9", "rd_stb", int'(rd_stb), 0);
        check_eq("R9", "rd_block", int'(rd_block), 0);
        check_eq("R9", "data_new", int'(data_new), 0);
        check_eq("R9", "dev_busy", int'(dev_busy), 0);
        check_eq("R9", "overflow", int'(overflow), 0);

        // queue mode, device free: bypass release
        q_mode = 1'b1;
        e = cyc + 1;
        expect_stb(e + MS, "R4");
        do_write();
        check_eq("R1", "data_new after write", int'(data_new), 1);
        tick(MS);
        check_eq("R1", "data_new after release", int'(data_new), 0);
        check_eq("R6", "dev_busy after release", int'(dev_busy), 1);
        tick(1);
        check_eq("R4", "rd_stb single cycle", int'(rd_stb), 0);

        // queue mode, device busy: word parked until done
        do_write();
        tick(10);
        check_eq("R5", "held data_new", int'(data_new), 1);
        check_eq("R5", "held dev_busy", int'(dev_busy), 1);
        d = cyc + 1;
        expect_stb(d, "R5");
        do_done();
        check_eq("R6", "busy kept on done+release", int'(dev_busy), 1);
        check_eq("R1", "data_new after departing release", int'(data_new), 0);

        // queue mode ignores requests
        do_req();
        tick(5);
        check_eq("R8", "data_new after ignored request", int'(data_new), 0);
        check_eq("R8", "rd_block after ignored request", int'(rd_block), 0);

        // done frees the device
        do_done();
        check_eq("R6", "dev_busy after done", int'(dev_busy), 0);

        // overflow: second write during separation
        e = cyc + 1;
        expect_stb(e + MS, "R7");
        do_write();
        check_eq("R7", "overflow on first write", int'(overflow), 0);
        do_write();
        check_eq("R7", "overflow on second write", int'(overflow), 1);
        tick(1);
        check_eq("R7", "overflow one cycle", int'(overflow), 0);
        tick(1);
        check_eq("R7", "data_new after release", int'(data_new), 0);
        do_done();

        // holder mode: write alone gives no release, request releases
        q_mode = 1'b0;
        do_write();
        tick(6);
        check_eq("R8", "holder keeps word", int'(data_new), 1);
        r = cyc + 1;
        expect_stb(r, "R2");
        do_req();
        check_eq("R2", "data_new after request", int'(data_new), 0);
        do_done();

        // same edge write and release: write wins
        do_write();
        r = cyc + 1;
        expect_stb(r, "R1");
        wr_stb = 1'b1;
        rd_req = 1'b1;
        tick(1);
        wr_stb = 1'b0;
        rd_req = 1'b0;
        check_eq("R1", "write wins data_new", int'(data_new), 1);
        r = cyc + 1;
        expect_stb(r, "R2");
        do_req();
        check_eq("R2", "data_new cleared", int'(data_new), 0);
        do_done();

        // refused request, served at first retry
        r = cyc + 1;
        expect_blk(r, "R3");
        expect_stb(r + LL, "R3");
        do_req();
        tick(9);
        do_write();
        tick(r + LL - cyc);
        check_eq("R3", "data_new after retry release", int'(data_new), 0);
        do_done();

        // refused twice, served at second retry
        r = cyc + 1;
        expect_blk(r, "R3");
        expect_blk(r + LL, "R3");
        expect_stb(r + 2 * LL, "R3");
        do_req();
        tick(LL + 5);
        do_write();
        tick(r + 2 * LL - cyc);
        check_eq("R3", "data_new after second retry", int'(data_new), 0);
        tick(3);

        check_eq("R10", "pending strobes", stb_cyc.size(), 0);
        check_eq("R3", "pending refusals", blk_cyc.size(), 0);
        report();
    end

endmodule